// File: doc/BRIEF.md
# Approximate String Matcher

This block scans a stream of text characters, one per clock, against a pattern held in registers. It reports every text position where some stretch of text that ends at that position is within a programmable number of edit errors of the pattern. An edit error is a substituted, an inserted or a dropped character. A pattern position may be flagged as a wildcard, and a wildcard position accepts any single character. The pattern length and the error limit are both set at run time, up to the sizes fixed by parameters. The defaults are 32 pattern characters and 8 errors.

Internally the block keeps one bit vector for each error level, from zero errors up to the maximum. Bit i of level d is set when the first i pattern characters match the recent text with no more than d errors. Each accepted character first produces a vector of per-position equality results, all computed in parallel. Every level is then updated in the same cycle. A level reads the level below it both before and after that level's own update, so the update logic chains from one level to the next. The match flag comes with a running count of accepted characters, and software uses this count to locate the end of each hit.

The pattern is loaded one position at a time. A restart input puts the matrix and the position count back into their starting state and keeps the loaded pattern.

Top module: `approx_matcher`

## Requirements
- R1: With error limit 0, `hit` is 1 exactly after the last character of each exact occurrence of the pattern, and overlapping occurrences are each reported.
- R2: A pattern position whose wildcard flag is 1 compares equal to every text character.
- R3: With error limit k, `hit` is 1 after a character exactly when some stretch of text ending at that character can be turned into the pattern with at most k substitutions, insertions and deletions.
- R4: Only the first `cfg_len` pattern positions (1 to MAX_LEN) take part in matching. Positions loaded beyond that length have no effect.
- R5: When `cfg_err` is greater than or equal to `cfg_len`, every accepted character produces a hit.
- R6: A character is accepted at a rising edge where `char_valid` is 1 and `restart` is 0. After that edge, `hit` reports the result for that character for exactly one cycle, and `hit_pos` equals the number of characters accepted since reset or restart. The first character is counted as 1.
- R7: A cycle with `char_valid` at 0 changes no match state. `hit` is 0 and `hit_pos` holds its value, whatever `char_in` carries.
- R8: `restart` takes priority over `char_valid`. It returns the matrix to its starting state and sets `hit_pos` to 0 and `hit` to 0. The pattern is kept.
- R9: Reset sets `hit` and `hit_pos` to 0. It also clears every pattern position to character value 0 with no wildcard.
- R10: A write with `pat_we` stores `pat_char` and `pat_wild` at pattern position `pat_idx`+1, where index 0 is the first pattern character. The write is used for characters accepted from the next cycle on and does not disturb the matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pat_we | input | 1 | Write strobe for one pattern position |
| pat_idx | input | IDX_W (5) | Zero-based pattern position to write |
| pat_char | input | CHAR_W (8) | Character stored at that position |
| pat_wild | input | 1 | Wildcard flag stored at that position |
| cfg_len | input | LEN_W (6) | Active pattern length, 1 to MAX_LEN |
| cfg_err | input | ERR_W (4) | Allowed number of edit errors, 0 to MAX_ERR |
| restart | input | 1 | Reload the starting matrix and clear the position count |
| char_valid | input | 1 | Qualifies `char_in` |
| char_in | input | CHAR_W (8) | Text character |
| hit | output | 1 | Match with at most `cfg_err` errors ends at the last accepted character |
| hit_pos | output | POS_W (32) | Count of accepted characters |

## Verification
The assertions assume the following about the inputs:
- `cfg_len` lies between 1 and MAX_LEN, and `cfg_err` does not exceed MAX_ERR.
- Both settings are changed only in cycles with no accepted character and are not changed in the cycle right after one.
- `pat_idx` is below MAX_LEN.

Under these conditions, the check that a small pattern under a large error limit hits on every character is well defined. The stimulus respects these conditions by changing settings only between text runs and always issuing a restart after such a change. Pattern writes are made only in cycles without a character.

// File: rtl/amatch_pkg.sv
package amatch_pkg;

   // Bits needed to index or hold n distinct values, never less than one.
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/amatch_pattern_store.sv
module amatch_pattern_store #(
   parameter int unsigned MAX_LEN = 32,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned IDX_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [CHAR_W-1:0] wr_char,
   input  logic              wr_wild,
   input  logic [CHAR_W-1:0] text_char,
   output logic [MAX_LEN:1]  cmp_vec
);

   logic [CHAR_W-1:0]  chr_q [MAX_LEN];
   logic [MAX_LEN-1:0] wild_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < MAX_LEN; p++) chr_q[p] <= '0;
         wild_q <= '0;
      end else if (wr_en) begin
         chr_q[wr_idx]  <= wr_char;
         wild_q[wr_idx] <= wr_wild;
      end
   end

   // One comparator per pattern position, all evaluated in parallel.
   for (genvar p = 0; p < MAX_LEN; p++) begin : g_cmp
      assign cmp_vec[p+1] = wild_q[p] | (chr_q[p] == text_char);
   end

endmodule

// File: rtl/amatch_err_row.sv
module amatch_err_row #(
   parameter int unsigned MAX_LEN = 32
) (
   input  logic [MAX_LEN-1:0] self_prev,
   input  logic [MAX_LEN:0]   lower_prev,
   input  logic [MAX_LEN-1:0] lower_next,
   input  logic [MAX_LEN:1]   cmp_vec,
   input  logic [MAX_LEN:0]   keep_mask,
   output logic [MAX_LEN:0]   row_next
);

   logic [MAX_LEN:0] extend_t, subst_t, drop_t, merged;

   // Bit 0 of every stored row is 1, so a left shift feeds a 1 into bit 1.
   assign extend_t = {self_prev, 1'b0} & {cmp_vec, 1'b1};
   assign subst_t  = {lower_prev[MAX_LEN-1:0], 1'b0};
   assign drop_t   = {lower_next, 1'b0};
   assign merged   = extend_t | subst_t | drop_t | lower_prev;
   assign row_next = (merged & keep_mask) | {{MAX_LEN{1'b0}}, 1'b1};

endmodule

// File: rtl/approx_matcher.sv
module approx_matcher
   import amatch_pkg::*;
#(
   parameter int unsigned MAX_LEN = 32,
   parameter int unsigned MAX_ERR = 8,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned POS_W   = 32,
   localparam int unsigned IDX_W  = idx_bits(MAX_LEN),
   localparam int unsigned LEN_W  = idx_bits(MAX_LEN + 1),
   localparam int unsigned ERR_W  = idx_bits(MAX_ERR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pat_we,
   input  logic [IDX_W-1:0]  pat_idx,
   input  logic [CHAR_W-1:0] pat_char,
   input  logic              pat_wild,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [ERR_W-1:0]  cfg_err,
   input  logic              restart,
   input  logic              char_valid,
   input  logic [CHAR_W-1:0] char_in,
   output logic              hit,
   output logic [POS_W-1:0]  hit_pos
);

   localparam int unsigned ROWS = MAX_ERR + 1;

   if (MAX_LEN < 2 || MAX_LEN > 64) begin : g_bad_len
      $error("approx_matcher: MAX_LEN must lie in 2..64");
   end
   if (MAX_ERR < 1) begin : g_bad_err
      $error("approx_matcher: MAX_ERR must be at least 1");
   end
   if (CHAR_W < 1 || POS_W < 2) begin : g_bad_width
      $error("approx_matcher: CHAR_W or POS_W too small");
   end

   logic [MAX_LEN:1] cmp_vec;
   logic [MAX_LEN:0] keep_mask;
   logic [ROWS-1:0]  tail_bits;
   logic             took_q;
   logic             step;

   assign step = char_valid & ~restart;

   amatch_pattern_store #(
      .MAX_LEN (MAX_LEN),
      .CHAR_W  (CHAR_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (pat_we),
      .wr_idx    (pat_idx),
      .wr_char   (pat_char),
      .wr_wild   (pat_wild),
      .text_char (char_in),
      .cmp_vec   (cmp_vec)
   );

   // Row bits above the programmed length are forced low on every update.
   for (genvar b = 0; b <= MAX_LEN; b++) begin : g_mask
      assign keep_mask[b] = (cfg_len >= LEN_W'(b));
   end

   for (genvar d = 0; d < ROWS; d++) begin : g_row
      logic [MAX_LEN:0]   q, nx, init_v;
      logic [MAX_LEN:0]   below_q;
      logic [MAX_LEN-1:0] below_nx;

      for (genvar b = 0; b <= MAX_LEN; b++) begin : g_init
         assign init_v[b] = (b <= d) ? 1'b1 : 1'b0;
      end

      if (d == 0) begin : g_base
         assign below_q  = '0;
         assign below_nx = '0;
      end else begin : g_upper
         assign below_q  = g_row[d-1].q;
         assign below_nx = g_row[d-1].nx[MAX_LEN-1:0];
      end

      amatch_err_row #(.MAX_LEN(MAX_LEN)) u_row (
         .self_prev  (q[MAX_LEN-1:0]),
         .lower_prev (below_q),
         .lower_next (below_nx),
         .cmp_vec    (cmp_vec),
         .keep_mask  (keep_mask),
         .row_next   (nx)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= init_v;
         else if (restart) q <= init_v;
         else if (step)    q <= nx;
      end

      assign tail_bits[d] = q[cfg_len];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         took_q  <= 1'b0;
         hit_pos <= '0;
      end else if (restart) begin
         took_q  <= 1'b0;
         hit_pos <= '0;
      end else begin
         took_q <= char_valid;
         if (char_valid) hit_pos <= hit_pos + 1'b1;
      end
   end

   assign hit = took_q & tail_bits[cfg_err];

endmodule

// File: rtl/approx_matcher_chk.sv
module approx_matcher_chk #(
   parameter int unsigned LEN_W = 6,
   parameter int unsigned ERR_W = 4,
   parameter int unsigned POS_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             restart,
   input logic             char_valid,
   input logic [LEN_W-1:0] cfg_len,
   input logic [ERR_W-1:0] cfg_err,
   input logic             hit,
   input logic [POS_W-1:0] hit_pos
);

   assert_hit_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> $past(char_valid && !restart));

   assert_pos_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !restart) |=> (hit_pos == $past(hit_pos) + 1'b1));

   assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!char_valid && !restart) |=> ($stable(hit_pos) && !hit));

   assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (hit_pos == '0 && !hit));

   assert_loose_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && !restart && (int'(cfg_err) >= int'(cfg_len))) |=> hit);

endmodule

bind approx_matcher approx_matcher_chk #(
   .LEN_W (LEN_W),
   .ERR_W (ERR_W),
   .POS_W (POS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .restart    (restart),
   .char_valid (char_valid),
   .cfg_len    (cfg_len),
   .cfg_err    (cfg_err),
   .hit        (hit),
   .hit_pos    (hit_pos)
);

// File: tb/approx_matcher_test.sv
module approx_matcher_test;

   localparam int CLK_PERIOD = 10;
   localparam int ML = 32;
   localparam int NCASE = 7;

   // Stimulus table: pattern text, wildcard flags, loaded length, active
   // length, error limit, text and text length. Expected hits come from an
   // edit-distance column model below.
   localparam logic [255:0] C_PAT [NCASE] = '{
      "abc", "a.c", "hello", "pattern", "abxyz", "abcd",
      "approximate matching in hardware"};
   localparam logic [31:0] C_WILD [NCASE] = '{0, 32'h2, 0, 0, 0, 0, 0};
   localparam int C_PLEN [NCASE] = '{3, 3, 5, 7, 5, 4, 32};
   localparam int C_LEN  [NCASE] = '{3, 3, 5, 7, 2, 4, 32};
   localparam int C_ERR  [NCASE] = '{0, 0, 1, 2, 0, 4, 8};
   localparam logic [255:0] C_TEXT [NCASE] = '{
      "xabcabcyab", "azcaacabcab", "jelloxhelo hallo", "a patern ptatern",
      "zabab", "qqqq", "approxmate matching in hardware!"};
   localparam int C_TLEN [NCASE] = '{10, 11, 16, 16, 5, 4, 32};

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pat_we;
   logic [4:0]  pat_idx;
   logic [7:0]  pat_char;
   logic        pat_wild;
   logic [5:0]  cfg_len;
   logic [3:0]  cfg_err;
   logic        restart;
   logic        char_valid;
   logic [7:0]  char_in;
   logic        hit;
   logic [31:0] hit_pos;

   always #(CLK_PERIOD/2) clk = ~clk;

   approx_matcher uut (
      .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_idx(pat_idx),
      .pat_char(pat_char), .pat_wild(pat_wild), .cfg_len(cfg_len),
      .cfg_err(cfg_err), .restart(restart), .char_valid(char_valid),
      .char_in(char_in), .hit(hit), .hit_pos(hit_pos));

   int checks = 0;
   int errors = 0;
   int exp_pos = 0;
   logic [7:0] sh_chr [ML];
   bit         sh_wild [ML];
   int m_len, m_err;
   int col [ML+1];

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic model_restart();
      for (int i = 0; i <= ML; i++) col[i] = i;
      exp_pos = 0;
   endtask

   // Column of minimum edit cost of each pattern prefix against text ending here.
   task automatic model_step(input logic [7:0] c, output bit e);
      int nc [ML+1];
      nc[0] = 0;
      for (int i = 1; i <= m_len; i++) begin
         int v;
         v = col[i-1] + ((sh_wild[i-1] || sh_chr[i-1] == c) ? 0 : 1);
         if (col[i] + 1 < v) v = col[i] + 1;
         if (nc[i-1] + 1 < v) v = nc[i-1] + 1;
         nc[i] = v;
      end
      for (int i = 1; i <= m_len; i++) col[i] = nc[i];
      e = (nc[m_len] <= m_err);
   endtask

   task automatic load(input int idx, input logic [7:0] ch, input bit w);
      pat_we = 1'b1; pat_idx = 5'(idx); pat_char = ch; pat_wild = w;
      tick();
      pat_we = 1'b0;
      sh_chr[idx] = ch; sh_wild[idx] = w;
   endtask

   task automatic set_cfg(input int l, input int e);
      cfg_len = 6'(l); cfg_err = 4'(e); m_len = l; m_err = e;
   endtask

   task automatic do_restart();
      restart = 1'b1; char_valid = 1'b0;
      tick();
      restart = 1'b0;
      model_restart();
      check("R8 restart hit", hit, 0);
      check("R8 restart pos", hit_pos, 0);
   endtask

   task automatic feed(input logic [7:0] c, input string req);
      bit e;
      char_valid = 1'b1; char_in = c;
      tick();
      char_valid = 1'b0;
      model_step(c, e);
      exp_pos++;
      check(req, hit, e);
      check("R6 position", hit_pos, exp_pos);
   endtask

   task automatic idle(input logic [7:0] c);
      char_valid = 1'b0; char_in = c;
      tick();
      check("R7 idle hit", hit, 0);
      check("R7 idle pos", hit_pos, exp_pos);
   endtask

   function automatic string req_name(input int k);
      case (k)
         0: return "R1 exact";
         1: return "R2 wildcard";
         4: return "R4 length";
         5: return "R5 loose limit";
         default: return "R3 edit errors";
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pat_we = 1'b0; pat_idx = '0; pat_char = '0; pat_wild = 1'b0;
      restart = 1'b0; char_valid = 1'b0; char_in = '0;
      set_cfg(1, 0);
      for (int p = 0; p < ML; p++) begin sh_chr[p] = '0; sh_wild[p] = 1'b0; end
      model_restart();
      tick(); tick();
      check("R9 reset hit", hit, 0);
      check("R9 reset pos", hit_pos, 0);
      rst_n = 1'b1;
      tick();

      // Table walk.
      for (int k = 0; k < NCASE; k++) begin
         for (int p = 0; p < C_PLEN[k]; p++)
            load(p, C_PAT[k][8*(C_PLEN[k]-1-p) +: 8], C_WILD[k][p]);
         set_cfg(C_LEN[k], C_ERR[k]);
         do_restart();
         for (int j = 0; j < C_TLEN[k]; j++)
            feed(C_TEXT[k][8*(C_TLEN[k]-1-j) +: 8], req_name(k));
      end

      // R7: idle cycles carrying junk leave a partial match intact.
      load(0, "a", 1'b0); load(1, "b", 1'b0);
      set_cfg(2, 0);
      do_restart();
      feed("a", "R7 before idle");
      idle("b"); idle("b"); idle("a");
      feed("b", "R7 resume after idle");
      idle("x");

      // R8: restart wins over a valid character and keeps the pattern.
      feed("a", "R8 prefix");
      restart = 1'b1; char_valid = 1'b1; char_in = "b";
      tick();
      restart = 1'b0; char_valid = 1'b0;
      model_restart();
      check("R8 restart over valid hit", hit, 0);
      check("R8 restart over valid pos", hit_pos, 0);
      feed("b", "R8 prefix dropped");
      feed("a", "R8 kept pattern");
      feed("b", "R8 kept pattern");
      check("R8 hit position", hit_pos, 3);
      idle("b");

      // R10: rewriting a position mid-stream keeps the matrix.
      do_restart();
      feed("a", "R10 prefix");
      load(1, "c", 1'b0);
      check("R10 write cycle hit", hit, 0);
      feed("c", "R10 new character used");
      feed("a", "R10 prefix");
      feed("b", "R10 old character gone");

      // R9: reset clears the stored pattern to character 0.
      rst_n = 1'b0;
      tick();
      check("R9 mid reset hit", hit, 0);
      check("R9 mid reset pos", hit_pos, 0);
      rst_n = 1'b1;
      for (int p = 0; p < ML; p++) begin sh_chr[p] = '0; sh_wild[p] = 1'b0; end
      set_cfg(1, 0);
      model_restart();
      feed(8'h00, "R9 cleared pattern");
      feed("a", "R9 cleared pattern");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule